// File: doc/BRIEF.md
# Multi-Mode 16-Bit Capture/Reload Timer

This block is a 16-bit timer/counter for a small microcontroller peripheral set. Its count is read and written as two bytes. Beside the count sits a 16-bit register that acts either as a capture target or as a reload source. A control byte and a two-bit option byte together select one operating mode: auto-reload, capture, baud-rate generation, up/down auto-reload, or clock-out. In each mode the count advances every machine cycle (timer operation) or on each falling edge of an external count pin (counter operation).

A second external pin, the trigger pin, can force a capture or a reload. In up/down mode its level sets the count direction instead. The block holds two sticky flags, overflow and external, and combines them into one interrupt request. It emits a one-cycle pulse for a serial-port partner on each rollover in the baud-rate and clock-out modes, and drives a clock-out pin that toggles on each rollover. Software reaches every register through a byte-wide port: writes are synchronous and reads are combinational.

Top module: `tmr16_top`

## Requirements
- R1: After reset, all six registers read 0x00, and irq, ovf_pulse and clk_out are 0.
- R2: Register map: address 0 is control, with bit0 run, bit1 counter select, bit2 capture select, bit3 trigger enable, bit4 receive-clock, bit5 transmit-clock, bit6 overflow flag and bit7 external flag. Address 1 is the option byte, with bit0 down enable and bit1 clock-out enable. Addresses 2 and 3 are the count low and high bytes. Addresses 4 and 5 are the capture/reload low and high bytes. Mode is decoded in this priority order: clock-out enable gives clock-out mode; otherwise bit4 or bit5 gives baud mode; otherwise capture select gives capture mode; otherwise down enable gives up/down mode; otherwise the mode is auto-reload.
- R3: In auto-reload timer operation, the count rises by 1 each cycle while run is 1. A carry out of 0xFFFF loads the reload value and sets the overflow flag. The overflow flag raises irq.
- R4: While run is 0, the count does not advance.
- R5: In capture mode with the trigger enabled, a trigger falling edge copies the count into the capture register and sets the external flag. A carry wraps the count to 0x0000 and sets the overflow flag.
- R6: In auto-reload mode with the trigger enabled, a trigger falling edge loads the count from the reload register and sets the external flag. With the trigger disabled, the edge changes nothing.
- R7: In baud and clock-out timer operation, the count rises by 6 each cycle. A carry loads the reload value and produces a one-cycle ovf_pulse, and it leaves the overflow flag unchanged.
- R8: In clock-out mode, each carry toggles clk_out in timer operation only. In counter operation, clk_out holds its value.
- R9: In up/down mode, a high trigger level counts up, and a carry reloads. A low level counts down, and a result below the reload value loads 0xFFFF. Both of these wraps set the overflow flag and toggle the external flag. In this mode the external flag does not raise irq.
- R10: In counter operation, the count advances by 1 for each falling edge of cnt_pin, three clock edges after the pin falls.
- R11: A pin edge that arrives in the same cycle as a control change to the mode or to run is discarded.
- R12: A software write to a count byte or a reload byte takes priority over a hardware update of that byte in the same cycle.
- R13: Both flags stay set until software writes control, and that write replaces them.
- R14: While run is 0, trigger edges still perform captures and reloads and set the external flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for both write and read |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for addr |
| cnt_pin | input | 1 | External count pin, falling edges counted |
| trig_pin | input | 1 | External trigger / direction pin |
| irq | output | 1 | Interrupt request from the flags |
| ovf_pulse | output | 1 | One-cycle rollover pulse for a serial partner |
| clk_out | output | 1 | Toggling clock-out pin |

## Verification
The bound checker watches, on every cycle, several properties of the block:
- the flags stay sticky between control writes;
- the count holds in stopped capture mode;
- ovf_pulse occurs only after a cycle spent in a rollover-pulse mode;
- clk_out changes only in clock-out timer operation;
- irq ignores the external flag in up/down mode.

Only the bench scenarios can show the actual count arithmetic. This covers the step of six, the reload and capture values, the down-count limit and its 0xFFFF load, the three-edge synchronizer latency, the discarding of an edge at a control change, and software write precedence.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_OPT  = 3'd1;
    localparam logic [ADDR_W-1:0] A_CLO  = 3'd2;
    localparam logic [ADDR_W-1:0] A_CHI  = 3'd3;
    localparam logic [ADDR_W-1:0] A_RLO  = 3'd4;
    localparam logic [ADDR_W-1:0] A_RHI  = 3'd5;

    localparam int B_RUN = 0;
    localparam int B_CSL = 1;
    localparam int B_CAP = 2;
    localparam int B_XEN = 3;
    localparam int B_RXC = 4;
    localparam int B_TXC = 5;
    localparam int B_OVF = 6;
    localparam int B_EXT = 7;

    typedef enum logic [2:0] {
        MD_RELOAD  = 3'd0,
        MD_CAPTURE = 3'd1,
        MD_BAUD    = 3'd2,
        MD_UPDOWN  = 3'd3,
        MD_CLKOUT  = 3'd4
    } mode_e;

    typedef struct packed {
        logic [BYTE_W-1:0] ctrl;
        logic              dn_en;
        logic              co_en;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  rld;
        logic              pulse;
        logic              clk_o;
    } tmr_state_t;
endpackage

// File: rtl/tmr16_edge.sv
module tmr16_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level,
    output logic fall
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_sync
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q[0] <= 1'b1;
                else        sync_q[0] <= pin;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q[i] <= 1'b1;
                else        sync_q[i] <= sync_q[i-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= sync_q[STAGES-1];
    end

    assign level = sync_q[STAGES-1];
    assign fall  = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/tmr16_mode.sv
module tmr16_mode
    import tmr16_pkg::*;
#(
    parameter bit HAS_DOWN   = 1'b1,
    parameter bit HAS_CLKOUT = 1'b1
) (
    input  logic [BYTE_W-1:0] ctrl,
    input  logic              dn_en,
    input  logic              co_en,
    output mode_e             mode
);
    always_comb begin
        if (HAS_CLKOUT && co_en)
            mode = MD_CLKOUT;
        else if (ctrl[B_RXC] || ctrl[B_TXC])
            mode = MD_BAUD;
        else if (ctrl[B_CAP])
            mode = MD_CAPTURE;
        else if (HAS_DOWN && dn_en)
            mode = MD_UPDOWN;
        else
            mode = MD_RELOAD;
    end
endmodule

// File: rtl/tmr16_arith.sv
module tmr16_arith
    import tmr16_pkg::*;
#(
    parameter int FAST_STEP = 6
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] rld,
    input  mode_e            mode,
    input  logic             adv,
    input  logic             fast,
    input  logic             up,
    output logic [CNT_W-1:0] nxt,
    output logic             wrap
);
    logic [CNT_W:0]   step;
    logic [CNT_W:0]   sum;
    logic [CNT_W-1:0] dec;

    always_comb begin
        step = fast ? (CNT_W+1)'(FAST_STEP) : (CNT_W+1)'(1);
        sum  = {1'b0, cnt} + step;
        dec  = cnt - CNT_W'(1);
        nxt  = cnt;
        wrap = 1'b0;
        if (adv) begin
            if (mode == MD_UPDOWN && !up) begin
                wrap = (dec < rld);
                nxt  = wrap ? {CNT_W{1'b1}} : dec;
            end else begin
                wrap = sum[CNT_W];
                if (wrap && mode != MD_CAPTURE)
                    nxt = rld;
                else
                    nxt = sum[CNT_W-1:0];
            end
        end
    end
endmodule

// File: rtl/tmr16_top.sv
module tmr16_top
    import tmr16_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FAST_STEP   = 6,
    parameter bit HAS_DOWN    = 1'b1,
    parameter bit HAS_CLKOUT  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              cnt_pin,
    input  logic              trig_pin,
    output logic              irq,
    output logic              ovf_pulse,
    output logic              clk_out
);
    tmr_state_t st_q, st_d;

    logic [BYTE_W-1:0] ctl_w;
    logic              dn_w, co_w;
    logic [CNT_W-1:0]  cnt_w;
    assign ctl_w = st_q.ctrl;
    assign dn_w  = st_q.dn_en;
    assign co_w  = st_q.co_en;
    assign cnt_w = st_q.cnt;

    logic cnt_lvl, cnt_fall, trg_lvl, trg_fall;

    tmr16_edge #(.STAGES(SYNC_STAGES)) u_cnt_edge (
        .clk(clk), .rst_n(rst_n), .pin(cnt_pin), .level(cnt_lvl), .fall(cnt_fall)
    );
    tmr16_edge #(.STAGES(SYNC_STAGES)) u_trg_edge (
        .clk(clk), .rst_n(rst_n), .pin(trig_pin), .level(trg_lvl), .fall(trg_fall)
    );

    // Write-side view of the configuration, used to spot mode and run changes.
    logic              wr_ctrl, wr_opt;
    logic [BYTE_W-1:0] ctrl_new;
    logic              dn_new, co_new;
    assign wr_ctrl  = wr_en && (addr == A_CTRL);
    assign wr_opt   = wr_en && (addr == A_OPT);
    assign ctrl_new = wr_ctrl ? wr_data : ctl_w;
    assign dn_new   = wr_opt ? wr_data[0] : dn_w;
    assign co_new   = wr_opt ? wr_data[1] : co_w;

    mode_e mode_now, mode_new;

    tmr16_mode #(.HAS_DOWN(HAS_DOWN), .HAS_CLKOUT(HAS_CLKOUT)) u_mode_now (
        .ctrl(ctl_w), .dn_en(dn_w), .co_en(co_w), .mode(mode_now)
    );
    tmr16_mode #(.HAS_DOWN(HAS_DOWN), .HAS_CLKOUT(HAS_CLKOUT)) u_mode_new (
        .ctrl(ctrl_new), .dn_en(dn_new), .co_en(co_new), .mode(mode_new)
    );

    logic chg, cnt_ev, trg_ev, csel, run, fast, adv;
    assign chg    = (mode_new != mode_now) || (ctrl_new[B_RUN] != ctl_w[B_RUN]);
    assign cnt_ev = cnt_fall & ~chg;
    assign trg_ev = trg_fall & ~chg & ctl_w[B_XEN];
    assign csel   = ctl_w[B_CSL];
    assign run    = ctl_w[B_RUN];
    assign fast   = ((mode_now == MD_BAUD) || (mode_now == MD_CLKOUT)) && !csel;
    assign adv    = run && (csel ? cnt_ev : 1'b1);

    logic [CNT_W-1:0] a_nxt;
    logic             a_wrap;

    tmr16_arith #(.FAST_STEP(FAST_STEP)) u_arith (
        .cnt(cnt_w), .rld(st_q.rld), .mode(mode_now), .adv(adv),
        .fast(fast), .up(trg_lvl), .nxt(a_nxt), .wrap(a_wrap)
    );

    logic ovf_set, ext_set, ext_tgl, ovf_base, ext_base;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        ovf_set    = 1'b0;
        ext_set    = 1'b0;
        ext_tgl    = 1'b0;

        case (mode_now)
            MD_RELOAD: begin
                if (trg_ev) begin
                    st_d.cnt = st_q.rld;
                    ext_set  = 1'b1;
                end else begin
                    st_d.cnt = a_nxt;
                    ovf_set  = a_wrap;
                end
            end
            MD_CAPTURE: begin
                st_d.cnt = a_nxt;
                ovf_set  = a_wrap;
                if (trg_ev) begin
                    st_d.rld = st_q.cnt;
                    ext_set  = 1'b1;
                end
            end
            MD_BAUD: begin
                st_d.cnt   = a_nxt;
                st_d.pulse = a_wrap;
                ext_set    = trg_ev;
            end
            MD_CLKOUT: begin
                st_d.cnt   = a_nxt;
                st_d.pulse = a_wrap;
                ext_set    = trg_ev;
                if (a_wrap && !csel)
                    st_d.clk_o = ~st_q.clk_o;
            end
            MD_UPDOWN: begin
                st_d.cnt = a_nxt;
                ovf_set  = a_wrap;
                ext_tgl  = a_wrap;
            end
            default: ;
        endcase

        // Software writes override the hardware result byte by byte.
        if (wr_en) begin
            case (addr)
                A_CTRL: st_d.ctrl[B_TXC:B_RUN] = wr_data[B_TXC:B_RUN];
                A_OPT: begin
                    st_d.dn_en = wr_data[0];
                    st_d.co_en = wr_data[1];
                end
                A_CLO: st_d.cnt[BYTE_W-1:0]      = wr_data;
                A_CHI: st_d.cnt[CNT_W-1:BYTE_W]  = wr_data;
                A_RLO: st_d.rld[BYTE_W-1:0]      = wr_data;
                A_RHI: st_d.rld[CNT_W-1:BYTE_W]  = wr_data;
                default: ;
            endcase
        end

        ovf_base = wr_ctrl ? wr_data[B_OVF] : ctl_w[B_OVF];
        ext_base = wr_ctrl ? wr_data[B_EXT] : ctl_w[B_EXT];
        st_d.ctrl[B_OVF] = ovf_base | ovf_set;
        st_d.ctrl[B_EXT] = ext_tgl ? ~ext_base : (ext_base | ext_set);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (addr)
            A_CTRL:  rd_data = ctl_w;
            A_OPT:   rd_data = {{(BYTE_W-2){1'b0}}, co_w, dn_w};
            A_CLO:   rd_data = cnt_w[BYTE_W-1:0];
            A_CHI:   rd_data = cnt_w[CNT_W-1:BYTE_W];
            A_RLO:   rd_data = st_q.rld[BYTE_W-1:0];
            A_RHI:   rd_data = st_q.rld[CNT_W-1:BYTE_W];
            default: rd_data = '0;
        endcase
    end

    assign irq       = ctl_w[B_OVF] | (ctl_w[B_EXT] & (mode_now != MD_UPDOWN));
    assign ovf_pulse = st_q.pulse;
    assign clk_out   = st_q.clk_o;
endmodule

// File: rtl/tmr16_chk.sv
module tmr16_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [2:0] addr,
    input logic [7:0] ctrl,
    input logic       dn_en,
    input logic       co_en,
    input logic [15:0] cnt,
    input logic       ovf_pulse,
    input logic       clk_out,
    input logic       irq
);
    p_flag_sticky_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctrl[6] && !(wr_en && addr == 3'd0)) |-> ctrl[6]);

    p_hold_stopped_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!ctrl[0] && ctrl[2] && !ctrl[4] && !ctrl[5] && !co_en
              && !(wr_en && (addr == 3'd2 || addr == 3'd3))) |-> $stable(cnt));

    p_pulse_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> $past(co_en || ctrl[4] || ctrl[5]));

    p_clkout_timer_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(clk_out) |-> $past(co_en && !ctrl[1]));

    p_updown_noext_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_en && !co_en && !ctrl[4] && !ctrl[5] && !ctrl[2] && !ctrl[6]) |-> !irq);
endmodule

bind tmr16_top tmr16_chk i_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .ctrl(ctl_w), .dn_en(dn_w), .co_en(co_w), .cnt(cnt_w),
    .ovf_pulse(ovf_pulse), .clk_out(clk_out), .irq(irq)
);

// File: tb/test_tmr16_top.sv
module test_tmr16_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       cnt_pin = 1'b1;
    logic       trig_pin = 1'b1;
    logic       irq, ovf_pulse, clk_out;

    int ntests = 0;
    int nfails = 0;

    always #10 clk = ~clk;

    tmr16_top i_tmr16_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .cnt_pin(cnt_pin), .trig_pin(trig_pin),
        .irq(irq), .ovf_pulse(ovf_pulse), .clk_out(clk_out)
    );

    // Ops: 0 write, 1 idle, 2 check register, 3 check pin (0 irq, 1 ovf_pulse, 2 clk_out),
    // 4 trigger pulse, 5 set trigger level.
    function automatic logic [31:0] mk(int r, int op, int a, int d);
        return {4'(r), 4'(op), 5'b0, 3'(a), 8'(d), 8'h00};
    endfunction

    localparam int NV = 121;
    localparam logic [31:0] VEC [NV] = '{
        // R3 reload overflow
        mk(3,0,2,8'hFE), mk(3,0,3,8'hFF), mk(3,0,4,8'hF0), mk(3,0,5,8'hFF), mk(3,0,0,8'h01),
        mk(3,1,0,2), mk(3,2,2,8'hF0), mk(3,2,3,8'hFF), mk(3,2,0,8'h41), mk(3,3,0,1),
        // R4 stopped holds
        mk(4,0,0,8'h40), mk(4,1,0,3), mk(4,2,2,8'hF1), mk(4,2,3,8'hFF),
        // R13 sticky flags, cleared by control write
        mk(13,2,0,8'h40), mk(13,3,0,1), mk(13,0,0,8'h00), mk(13,2,0,8'h00), mk(13,3,0,0),
        // R5 capture on trigger edge while stopped (R14)
        mk(5,0,2,8'h10), mk(5,0,3,8'h00), mk(5,0,0,8'h0C), mk(14,4,0,0),
        mk(5,2,4,8'h10), mk(5,2,5,8'h00), mk(14,2,0,8'h8C),
        // R5 capture overflow wraps to zero
        mk(5,0,0,8'h00), mk(5,0,2,8'hFF), mk(5,0,3,8'hFF), mk(5,0,4,8'hAA), mk(5,0,0,8'h05),
        mk(5,1,0,1), mk(5,2,2,8'h00), mk(5,2,3,8'h00), mk(5,2,0,8'h45), mk(5,2,4,8'hAA),
        mk(5,0,0,8'h00),
        // R6 forced reload by trigger
        mk(6,0,4,8'h34), mk(6,0,5,8'h12), mk(6,0,2,8'h00), mk(6,0,3,8'h00), mk(6,0,0,8'h08),
        mk(6,4,0,0), mk(6,2,2,8'h34), mk(6,2,3,8'h12), mk(6,2,0,8'h88),
        // R6 trigger disabled: no effect
        mk(6,0,0,8'h00), mk(6,0,2,8'h00), mk(6,0,3,8'h00), mk(6,4,0,0),
        mk(6,2,2,8'h00), mk(6,2,3,8'h00), mk(6,2,0,8'h00),
        // R7 baud mode step of six
        mk(7,0,4,8'hF0), mk(7,0,5,8'hFF), mk(7,0,2,8'hF0), mk(7,0,3,8'hFF), mk(7,0,0,8'h11),
        mk(7,1,0,3), mk(7,3,1,1), mk(7,2,2,8'hF0), mk(7,2,3,8'hFF), mk(7,2,0,8'h11),
        mk(7,1,0,1), mk(7,3,1,0), mk(7,2,2,8'hF6), mk(7,0,0,8'h00),
        // R8 clock-out toggles, priority over baud bit (R2)
        mk(8,0,1,8'h02), mk(8,0,2,8'hF0), mk(8,0,3,8'hFF), mk(2,0,0,8'h11),
        mk(8,1,0,3), mk(8,3,2,1), mk(8,2,0,8'h11), mk(8,1,0,3), mk(8,3,2,0),
        mk(8,0,0,8'h00), mk(8,0,1,8'h00),
        // R2 down enable ignored when capture selected
        mk(2,0,1,8'h01), mk(2,0,2,8'h00), mk(2,0,3,8'h00), mk(2,0,0,8'h0C),
        mk(2,4,0,0), mk(2,2,0,8'h8C), mk(2,2,4,8'h00), mk(2,0,0,8'h00),
        // R9 count down below reload
        mk(9,0,4,8'h00), mk(9,0,5,8'h01), mk(9,0,2,8'h01), mk(9,0,3,8'h01), mk(9,5,0,0),
        mk(9,1,0,4), mk(9,0,0,8'h01), mk(9,1,0,2), mk(9,2,2,8'hFF), mk(9,2,3,8'hFF),
        mk(9,2,0,8'hC1), mk(9,3,0,1), mk(9,0,0,8'h81), mk(9,3,0,0), mk(9,0,0,8'h00),
        // R9 count up with reload
        mk(9,0,2,8'hFF), mk(9,0,3,8'hFF), mk(9,5,0,1), mk(9,1,0,4), mk(9,0,0,8'h01),
        mk(9,1,0,1), mk(9,2,2,8'h00), mk(9,2,3,8'h01), mk(9,2,0,8'hC1), mk(9,0,0,8'h00),
        mk(9,0,1,8'h00),
        // R12 software write beats hardware increment
        mk(12,0,4,8'h00), mk(12,0,5,8'h00), mk(12,0,2,8'h10), mk(12,0,3,8'h00), mk(12,0,0,8'h01),
        mk(12,0,2,8'h55), mk(12,2,2,8'h55), mk(12,2,3,8'h00), mk(12,0,0,8'h00)
    };

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_reg(input int r, input logic [2:0] a, input logic [7:0] e);
        addr = a;
        #1;
        ntests++;
        if (rd_data !== e) begin
            nfails++;
            $display("FAIL R%0d reg %0d act=%02h exp=%02h", r, a, rd_data, e);
        end
    endtask

    task automatic chk_pin(input int r, input int p, input logic e);
        logic v;
        #1;
        v = (p == 0) ? irq : (p == 1) ? ovf_pulse : clk_out;
        ntests++;
        if (v !== e) begin
            nfails++;
            $display("FAIL R%0d pin %0d act=%0b exp=%0b", r, p, v, e);
        end
    endtask

    task automatic trig_pulse();
        trig_pin = 1'b0; idle(4);
        trig_pin = 1'b1; idle(4);
    endtask

    task automatic cnt_pulse();
        cnt_pin = 1'b0; idle(4);
        cnt_pin = 1'b1; idle(4);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfails++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  [TB] %0d tests run, %0d failed", ntests, nfails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 6; a++) chk_reg(1, 3'(a), 8'h00);
        chk_pin(1, 0, 1'b0);
        chk_pin(1, 1, 1'b0);
        chk_pin(1, 2, 1'b0);

        for (int i = 0; i < NV; i++) begin
            automatic int       r  = int'(VEC[i][31:28]);
            automatic int       op = int'(VEC[i][27:24]);
            automatic logic [2:0] a = VEC[i][18:16];
            automatic logic [7:0] d = VEC[i][15:8];
            case (op)
                0: wr(a, d);
                1: idle(int'(d));
                2: chk_reg(r, a, d);
                3: chk_pin(r, int'(a), d[0]);
                4: trig_pulse();
                5: begin trig_pin = d[0]; #1; end
                default: ;
            endcase
        end

        // R10 counter operation
        wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(3'd0, 8'h03);
        cnt_pin = 1'b0; idle(4);
        chk_reg(10, 3'd2, 8'h01);
        cnt_pin = 1'b1; idle(4);
        chk_reg(10, 3'd2, 8'h01);
        cnt_pulse();
        chk_reg(10, 3'd2, 8'h02);
        wr(3'd0, 8'h00);

        // R8 clock-out in counter operation keeps clk_out
        wr(3'd1, 8'h02); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
        wr(3'd4, 8'h12); wr(3'd5, 8'h00); wr(3'd0, 8'h03);
        cnt_pulse();
        chk_reg(8, 3'd2, 8'h12);
        chk_reg(8, 3'd3, 8'h00);
        chk_pin(8, 2, 1'b0);
        wr(3'd0, 8'h00); wr(3'd1, 8'h00);

        // R11 edge discarded when run changes in the same cycle
        wr(3'd4, 8'h34); wr(3'd5, 8'h12); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
        wr(3'd0, 8'h08);
        trig_pin = 1'b0;
        idle(2);
        wr(3'd0, 8'h09);
        chk_reg(11, 3'd2, 8'h00);
        chk_reg(11, 3'd0, 8'h09);
        wr(3'd0, 8'h00);
        trig_pin = 1'b1; idle(4);

        $display("  [TB] %0d tests run, %0d failed", ntests, nfails);
        $finish;
    end
endmodule